// File: doc/BRIEF.md
# I2C Configuration Register Target

This block lets a host on a two-wire I2C-compatible bus read and write a small bank of 8-bit configuration registers for a serial link endpoint, and it produces the configuration word that the rest of the endpoint consumes. SCL and SDA are sampled through synchronizers into the system clock. SDA is handled as open drain: the block only ever pulls it low through `sda_oe_o` and otherwise leaves it to the pull-up. A 3-bit select code, standing in for an external address-strap network, picks one of five 7-bit device addresses, so several endpoints can sit on one bus.

Register 0 is a master switch. While it holds any value other than 01h, the configuration word is taken straight from the strap/control pin inputs. Once a host writes 01h there, the word is assembled from registers 1 and up, and the pins no longer matter. A write transfer carries the register pointer in its first data byte and register data in the bytes after it. A read transfer returns bytes from the current pointer onwards. The pointer steps after every byte in both directions.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset all registers hold 00h, the register pointer is 0, `cfg_o` equals `cfg_strap_i`, and SDA is released.
- R2: `cfg_o` equals the register contents only while register 0 holds exactly 01h, with register k in bits [8k-1:8k-8] of `cfg_o`. Any other value of register 0, including 02h, makes `cfg_o` follow `cfg_strap_i`.
- R3: The device address is ADDR_BASE + `addr_sel_i` for select codes 0 to 4. Codes 5 to 7 fall back to ADDR_BASE. The default ADDR_BASE is 2Ch.
- R4: The address byte carries the 7-bit address in bits 7:1 and the direction in bit 0, with 1 meaning read. On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and neither acknowledges nor writes anything until the next START or STOP.
- R5: In a write, every data byte is acknowledged. The first data byte loads the pointer from its low log2(NUM_REGS) bits. Each later byte is written to the register at the pointer, and the pointer then increments modulo NUM_REGS.
- R6: A read sends the register at the current pointer MSB first and increments the pointer modulo NUM_REGS after each byte. It keeps sending while the host acknowledges.
- R7: A host NACK after a read byte ends the read. SDA then stays released until the next START or STOP.
- R8: A repeated START, with no STOP before it, restarts address decoding and can turn a write into a read.
- R9: SDA is never driven high. The drive-low enable changes only in the system clock after a detected SCL falling edge.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a byte discards that partial byte, so no register and no pointer change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 3 | Device address select code |
| cfg_strap_i | input | (NUM_REGS-1)*8 | Configuration from control/strap pins |
| cfg_o | output | (NUM_REGS-1)*8 | Effective configuration word |

## Verification
Some properties are checked on every cycle:
- The drive enable changes only right after a detected SCL fall.
- SDA is held low throughout the address-acknowledge state and released in the idle and ignore states.
- At most one of the pointer-load, write and read-advance strobes fires in any cycle.
- The pointer steps by exactly one after each write or read advance.
- The configuration word stays still unless a register write or a strap change has just occurred.

Other behaviours only the bench scenarios can show. These are:
- the byte values returned by reads, including the wrap from the last register back to register 0;
- address matching for each select code, including the fallback codes;
- the exact 01h override condition;
- NACK-and-ignore after a wrong address;
- release of SDA after a host NACK;
- a STOP that cuts a byte short.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

  // Five strap-selected addresses; codes above four use the base address.
  function automatic logic [6:0] pick_addr(input logic [6:0] base, input logic [2:0] sel);
    if (sel <= 3'd4) return base + {4'b0000, sel};
    return base;
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_s,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic       wr_en,
  output logic       rd_inc,
  output logic [7:0] wr_byte,
  output tgt_state_e state
);

  tgt_state_e state_q, state_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] shift_q, shift_d;
  logic       rdy_q, rdy_d;
  logic       rw_q, rw_d;
  logic       first_q, first_d;
  logic       hack_q, hack_d;
  logic       oe_q, oe_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    rdy_d    = rdy_q;
    rw_d     = rw_q;
    first_d  = first_q;
    hack_d   = hack_q;
    oe_d     = oe_q;
    ptr_load = 1'b0;
    wr_en    = 1'b0;
    rd_inc   = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = 3'd0;
      rdy_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = 3'd0;
      rdy_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise && !rdy_q) begin
            shift_d = {shift_q[6:0], sda_s};
            cnt_d   = cnt_q + 3'd1;
            if (cnt_q == 3'd7) rdy_d = 1'b1;
          end else if (scl_fall && rdy_q) begin
            rdy_d = 1'b0;
            cnt_d = 3'd0;
            if (state_q == ST_ADDR) begin
              if (shift_q[7:1] == dev_addr) begin
                oe_d    = 1'b1;
                rw_d    = shift_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IGNORE;
              end
            end else begin
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
              first_d = 1'b0;
              if (first_q) ptr_load = 1'b1;
              else         wr_en    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = 3'd0;
            if (rw_q) begin
              shift_d = rd_data;
              oe_d    = ~rd_data[7];
              rd_inc  = 1'b1;
              state_d = ST_RD_BYTE;
            end else begin
              oe_d    = 1'b0;
              first_d = 1'b1;
              state_d = ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              shift_d = {shift_q[6:0], 1'b0};
              oe_d    = ~shift_q[6];
              cnt_d   = cnt_q + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = 3'd0;
            if (hack_q) begin
              shift_d = rd_data;
              oe_d    = ~rd_data[7];
              rd_inc  = 1'b1;
              state_d = ST_RD_BYTE;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      shift_q <= 8'h00;
      rdy_q   <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      hack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rdy_q   <= rdy_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      hack_q  <= hack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_byte = shift_q;
  assign state   = state_q;

endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
  parameter int NUM_REGS = 4,
  localparam int PTR_W   = $clog2(NUM_REGS),
  localparam int CFG_W   = (NUM_REGS - 1) * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic             wr_en,
  input  logic             rd_inc,
  input  logic [7:0]       wr_byte,
  input  logic [CFG_W-1:0] strap_i,
  output logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr_o,
  output logic [CFG_W-1:0] cfg_o
);

  localparam logic [7:0] OVERRIDE_ON = 8'h01;

  logic [NUM_REGS*8-1:0] regs_flat;
  logic [PTR_W-1:0]      ptr_q, ptr_d;
  logic                  override;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load)              ptr_d = wr_byte[PTR_W-1:0];
    else if (wr_en || rd_inc)  ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    logic       r_en;
    assign r_en = wr_en && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= 8'h00;
      else if (r_en) r_q <= wr_byte;
    end
    assign regs_flat[g*8 +: 8] = r_q;
  end

  assign rd_data  = regs_flat[{ptr_q, 3'b000} +: 8];
  assign override = (regs_flat[7:0] == OVERRIDE_ON);
  assign cfg_o    = override ? regs_flat[NUM_REGS*8-1:8] : strap_i;
  assign ptr_o    = ptr_q;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int          NUM_REGS    = 4,
  parameter logic [6:0]  ADDR_BASE   = 7'h2C,
  parameter int          SYNC_STAGES = 2,
  localparam int         CFG_W       = (NUM_REGS - 1) * 8,
  localparam int         PTR_W       = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [2:0]       addr_sel_i,
  input  logic [CFG_W-1:0] cfg_strap_i,
  output logic [CFG_W-1:0] cfg_o
);

  logic [1:0]       rst_pipe;
  logic             rst_n;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]       dev_addr;
  logic [7:0]       rd_data, wr_byte;
  logic             ptr_load, wr_en, rd_inc;
  logic [PTR_W-1:0] ptr;
  tgt_state_e       state;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  assign dev_addr = pick_addr(ADDR_BASE, addr_sel_i);

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .ptr_load  (ptr_load),
    .wr_en     (wr_en),
    .rd_inc    (rd_inc),
    .wr_byte   (wr_byte),
    .state     (state)
  );

  i2c_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .wr_en    (wr_en),
    .rd_inc   (rd_inc),
    .wr_byte  (wr_byte),
    .strap_i  (cfg_strap_i),
    .rd_data  (rd_data),
    .ptr_o    (ptr),
    .cfg_o    (cfg_o)
  );

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk
  import i2c_cfg_pkg::*;
#(
  parameter int PTR_W = 2,
  parameter int CFG_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             sda_oe,
  input tgt_state_e       state,
  input logic             wr_en,
  input logic             ptr_load,
  input logic             rd_inc,
  input logic [PTR_W-1:0] ptr,
  input logic [CFG_W-1:0] cfg_strap,
  input logic [CFG_W-1:0] cfg
);

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall)); // R9

  AST_ADDR_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> sda_oe); // R4

  AST_RELEASED_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, ptr_load, rd_inc})); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en || rd_inc) |-> (ptr == PTR_W'($past(ptr) + 1'b1))); // R6

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(cfg_strap)) |-> $stable(cfg)); // R2

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.PTR_W(PTR_W), .CFG_W(CFG_W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .scl_fall  (scl_fall),
  .sda_oe    (sda_oe_o),
  .state     (state),
  .wr_en     (wr_en),
  .ptr_load  (ptr_load),
  .rd_inc    (rd_inc),
  .ptr       (ptr),
  .cfg_strap (cfg_strap_i),
  .cfg       (cfg_o)
);

// File: tb/test_i2c_cfg_target.sv
module test_i2c_cfg_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int CFG_W      = 24;

  logic             clk;
  logic             rst_n;
  logic             host_scl;
  logic             host_low;
  logic             dut_oe;
  logic             sda_bus;
  logic [2:0]       addr_sel;
  logic [CFG_W-1:0] strap;
  logic [CFG_W-1:0] cfg;

  int n_tests = 0;
  int n_fail  = 0;
  int oe_viol = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] obs_q[$];

  assign sda_bus = ~(host_low | dut_oe);

  i2c_cfg_target i_i2c_cfg_target (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .scl_i       (host_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (dut_oe),
    .addr_sel_i  (addr_sel),
    .cfg_strap_i (strap),
    .cfg_o       (cfg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R9: drive enable must not move while SCL is high
  logic prev_oe;
  always @(posedge clk) begin
    prev_oe <= dut_oe;
    if (rst_n && host_scl && (dut_oe !== prev_oe)) oe_viol++;
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        logic [31:0] e, o;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        o = obs_q.pop_front();
        n_tests++;
        if (o !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, o, e);
        end
      end
    end
  end

  task automatic expect_val(input logic [31:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic observe(input logic [31:0] v);
    obs_q.push_back(v);
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_q(2);
    host_low = 1'b0;
    wait_q(Q);
    host_scl = 1'b1;
    wait_q(Q);
    host_low = 1'b1;
    wait_q(Q);
    host_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_q(2);
    host_low = 1'b1;
    wait_q(Q);
    host_scl = 1'b1;
    wait_q(Q);
    host_low = 1'b0;
    wait_q(Q);
  endtask

  task automatic send_bit(input logic b);
    wait_q(2);
    host_low = ~b;
    wait_q(Q);
    host_scl = 1'b1;
    wait_q(2*Q);
    host_scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string t);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_q(2);
    host_low = 1'b0;
    wait_q(Q);
    host_scl = 1'b1;
    wait_q(Q);
    ack = ~sda_bus;
    wait_q(Q);
    host_scl = 1'b0;
    expect_val({31'd0, exp_ack}, t);
    observe({31'd0, ack});
  endtask

  task automatic read_byte(input logic host_ack, input logic [7:0] exp_b, input string t);
    logic [7:0] b;
    wait_q(2);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_q(Q);
      host_scl = 1'b1;
      wait_q(Q);
      b[i] = sda_bus;
      wait_q(Q);
      host_scl = 1'b0;
    end
    send_bit(~host_ack);
    wait_q(2);
    host_low = 1'b0;
    expect_val({24'd0, exp_b}, t);
    observe({24'd0, b});
  endtask

  task automatic check_cfg(input logic [CFG_W-1:0] e, input string t);
    wait_q(4);
    expect_val({8'd0, e}, t);
    observe({8'd0, cfg});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_q(5);
    rst_n = 1'b1;
    wait_q(5);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    host_scl = 1'b1;
    host_low = 1'b0;
    addr_sel = 3'd2;              // address 2Eh
    strap    = 24'hA5C31E;
    do_reset();

    // R1: reset state
    check_cfg(24'hA5C31E, "R1 cfg after reset");
    expect_val(32'd0, "R1 sda released");
    observe({31'd0, dut_oe});

    // R4/R5: write registers 1..3, override still off
    bus_start();
    write_byte(8'h5C, 1'b1, "R4 address ack");
    write_byte(8'h01, 1'b1, "R5 pointer ack");
    write_byte(8'h11, 1'b1, "R5 data ack");
    write_byte(8'h22, 1'b1, "R5 data ack");
    write_byte(8'h33, 1'b1, "R5 data ack");
    bus_stop();
    check_cfg(24'hA5C31E, "R2 override off");

    // R2: enable override
    bus_start();
    write_byte(8'h5C, 1'b1, "R4 address ack");
    write_byte(8'h00, 1'b1, "R5 pointer ack");
    write_byte(8'h01, 1'b1, "R5 data ack");
    bus_stop();
    check_cfg(24'h332211, "R2 override on");

    // R8/R6/R7: pointer write, repeated start, read with wrap, NACK
    bus_start();
    write_byte(8'h5C, 1'b1, "R4 address ack");
    write_byte(8'h01, 1'b1, "R5 pointer ack");
    bus_start();
    write_byte(8'h5D, 1'b1, "R8 read address after repeated start");
    read_byte(1'b1, 8'h11, "R6 read reg1");
    read_byte(1'b1, 8'h22, "R6 read reg2");
    read_byte(1'b1, 8'h33, "R6 read reg3");
    read_byte(1'b0, 8'h01, "R6 read wraps to reg0");
    read_byte(1'b0, 8'hFF, "R7 released after host nack");
    bus_stop();

    // R4: wrong address is ignored
    bus_start();
    write_byte(8'h58, 1'b0, "R4 mismatch nack");
    write_byte(8'h00, 1'b0, "R4 ignored byte");
    write_byte(8'h00, 1'b0, "R4 ignored byte");
    bus_stop();
    check_cfg(24'h332211, "R4 cfg unchanged after ignored write");

    // R3: select codes
    addr_sel = 3'd6;              // falls back to 2Ch
    bus_start();
    write_byte(8'h58, 1'b1, "R3 code 6 uses base");
    write_byte(8'h02, 1'b1, "R5 pointer ack");
    write_byte(8'h5A, 1'b1, "R5 data ack");
    bus_stop();
    check_cfg(24'h335A11, "R3 write via fallback address");
    addr_sel = 3'd4;              // 30h
    bus_start();
    write_byte(8'h60, 1'b1, "R3 code 4 address");
    bus_stop();
    addr_sel = 3'd7;
    bus_start();
    write_byte(8'h5C, 1'b0, "R3 code 7 not 2Eh");
    bus_stop();

    // R10: stop in the middle of a data byte
    addr_sel = 3'd2;
    bus_start();
    write_byte(8'h5C, 1'b1, "R4 address ack");
    write_byte(8'h03, 1'b1, "R5 pointer ack");
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    bus_stop();
    check_cfg(24'h335A11, "R10 partial byte discarded");
    bus_start();
    write_byte(8'h5D, 1'b1, "R4 read address ack");
    read_byte(1'b0, 8'h33, "R10 pointer kept at 3");
    bus_stop();

    // R2: value 02h is not the override code
    bus_start();
    write_byte(8'h5C, 1'b1, "R4 address ack");
    write_byte(8'h00, 1'b1, "R5 pointer ack");
    write_byte(8'h02, 1'b1, "R5 data ack");
    bus_stop();
    check_cfg(24'hA5C31E, "R2 02h gives strap");
    strap = 24'h123456;
    check_cfg(24'h123456, "R2 strap follows pins");

    // R1: reset mid-run clears registers and pointer
    do_reset();
    check_cfg(24'h123456, "R1 cfg after second reset");
    bus_start();
    write_byte(8'h5D, 1'b1, "R4 read address ack");
    read_byte(1'b1, 8'h00, "R1 reg0 cleared");
    read_byte(1'b0, 8'h00, "R1 reg1 cleared");
    bus_stop();

    // R9 summary of drive-timing monitor
    expect_val(32'd0, "R9 drive change while SCL high");
    observe(oe_viol);

    wait_q(10);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard (all requirements): got %0d pending expected 0", exp_q.size() + obs_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule